// File: doc/BRIEF.md
# Time-of-Day Register Interface

This block is the host-facing register file of a time-of-day clock. A simple single-beat 32-bit port lets software read the running time, set a new time, and program the increment period, the offset-adjust run and the drift-correction pair. The time accumulation itself lives in a separate counter core. This block feeds that core with the programmed settings. It also passes a one-cycle load strobe with a new time, and a one-cycle start strobe for an offset adjustment.

The time is 48 bits of seconds plus 32 bits of nanoseconds, so it does not fit one host word. To make a multi-word access coherent, a read of the nanosecond word freezes the seconds in a snapshot. The seconds reads that follow return the snapshot. Writes go the other way: the two seconds words are only staged. The nanosecond write then hands all three words to the core in a single cycle.

Top module: `tod_host_regs`

## Requirements
- R1: After reset the period output and its register hold the parameter NOMINAL_PERIOD. The adjust period, adjust count, drift step and drift interval are zero. No strobe or read-valid is active.
- R2: A read at offset 0x108 returns the live nanosecond input and captures the live seconds into a snapshot. Reads at 0x100 and 0x104 return the snapshot, not the live seconds. The snapshot is zero until the first nanosecond read.
- R3: Offset 0x100 returns seconds bits 47:32 in data bits 15:0 with data bits 31:16 zero. Offset 0x104 returns seconds bits 31:0.
- R4: Writes to 0x100 and 0x104 only stage the seconds and raise no load strobe. A write to 0x108 raises `time_load` for exactly the next cycle, with `load_sec` set to the staged high and low seconds and `load_ns` set to the written word.
- R5: Offset 0x038 reads the parameter CLK_HZ, and writes to it have no effect.
- R6: The period register is at 0x110 and the adjust period at 0x114, each 20 bits wide. The drift step is at 0x11C and the drift interval at 0x120, each 16 bits wide. Each drives its output from the cycle after the write. Data bits above each field are dropped on write and read back as zero.
- R7: A read at 0x118 returns the live remaining adjust count input, zero-extended to 32 bits.
- R8: A write of a nonzero field to 0x118 raises `adj_start` for exactly the next cycle, with `adj_count` set to data bits 19:0 and `adj_period` holding its current value. A write whose bits 19:0 are zero raises no start.
- R9: A read of any other address returns zero. A write to one changes no output.
- R10: `host_rvalid` is high exactly in the cycle after a read strobe and low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Single-cycle access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| live_sec | input | SEC_W | Running seconds from the core |
| live_ns | input | 32 | Running nanoseconds from the core |
| live_adj_left | input | CNT_W | Remaining offset-adjust cycles from the core |
| time_load | output | 1 | One-cycle time load strobe |
| load_sec | output | SEC_W | Seconds to load |
| load_ns | output | 32 | Nanoseconds to load |
| period | output | PER_W | Increment period |
| adj_period | output | PER_W | Period used during an offset adjustment |
| adj_start | output | 1 | One-cycle offset-adjust start strobe |
| adj_count | output | CNT_W | Cycle count of the started adjustment |
| drift_step | output | DRIFT_W | Drift correction amount |
| drift_interval | output | DRIFT_W | Cycles between drift corrections |

## Verification
Several properties are checked on every cycle. The read-valid timing holds. A load strobe follows a nanosecond write and nothing else. A start strobe follows only a nonzero count write. The snapshot stays frozen between nanosecond reads, and the address decode hits at most one register. Some behaviours need the bench's scenarios: a snapshot value that differs from the live seconds after time moves on, the exact seconds packed into a load, the dropped upper bits, and the constant frequency word.

// File: rtl/tod_regs_pkg.sv
package tod_regs_pkg;
  localparam int NREG = 9;
  localparam int DATA_W = 32;

  typedef enum int {
    RG_FREQ = 0, RG_SEC_HI = 1, RG_SEC_LO = 2, RG_NSEC = 3, RG_PERIOD = 4,
    RG_ADJ_PER = 5, RG_ADJ_CNT = 6, RG_DRIFT = 7, RG_DRIFT_RATE = 8
  } reg_idx_e;

  // byte offset of each register slot
  function automatic logic [15:0] reg_offset(input int idx);
    case (idx)
      0: reg_offset = 16'h0038;
      1: reg_offset = 16'h0100;
      2: reg_offset = 16'h0104;
      3: reg_offset = 16'h0108;
      4: reg_offset = 16'h0110;
      5: reg_offset = 16'h0114;
      6: reg_offset = 16'h0118;
      7: reg_offset = 16'h011C;
      default: reg_offset = 16'h0120;
    endcase
  endfunction

  // keep the low w bits of a host word, clear the rest
  function automatic logic [DATA_W-1:0] keep_low(input logic [DATA_W-1:0] v, input int w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
    keep_low = v & m;
  endfunction
endpackage

// File: rtl/tod_addr_decode.sv
module tod_addr_decode
  import tod_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    localparam logic [15:0] OFF = reg_offset(i);
    assign sel[i] = (addr == OFF[ADDR_W-1:0]);
  end

  always_comb begin
    p_sel_onehot_r9: assert ($onehot0(sel));
  end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
  parameter int SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SEC_W-1:0] live_sec,
  output logic [SEC_W-1:0] snap_sec
);
  always_ff @(posedge clk) begin
    if (!rst_n)       snap_sec <= '0;
    else if (capture) snap_sec <= live_sec;
  end

  p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap_sec));
endmodule

// File: rtl/tod_time_stage.sv
module tod_time_stage #(
  parameter int SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             wr_ns,
  input  logic [31:0]      wdata,
  output logic             time_load,
  output logic [SEC_W-1:0] load_sec,
  output logic [31:0]      load_ns
);
  localparam int HI_W = SEC_W - 32;

  logic [HI_W-1:0] stage_hi;
  logic [31:0]     stage_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi  <= '0;
      stage_lo  <= '0;
      time_load <= 1'b0;
      load_sec  <= '0;
      load_ns   <= '0;
    end else begin
      if (wr_hi) stage_hi <= wdata[HI_W-1:0];
      if (wr_lo) stage_lo <= wdata;
      time_load <= wr_ns;
      if (wr_ns) begin
        load_sec <= {stage_hi, stage_lo};
        load_ns  <= wdata;
      end
    end
  end

  p_load_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ns |=> $stable(load_sec) && $stable(load_ns));
endmodule

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_regs_pkg::*;
#(
  parameter int PER_W = 20,
  parameter int CNT_W = 20,
  parameter int DRIFT_W = 16,
  parameter logic [PER_W-1:0] NOMINAL_PERIOD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NREG-1:0]    sel,
  input  logic [31:0]        wdata,
  output logic [PER_W-1:0]   period,
  output logic [PER_W-1:0]   adj_period,
  output logic               adj_start,
  output logic [CNT_W-1:0]   adj_count,
  output logic [DRIFT_W-1:0] drift_step,
  output logic [DRIFT_W-1:0] drift_interval
);
  logic evt_cnt_write;
  assign evt_cnt_write = wr_en && sel[RG_ADJ_CNT] && (wdata[CNT_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period         <= NOMINAL_PERIOD;
      adj_period     <= '0;
      adj_start      <= 1'b0;
      adj_count      <= '0;
      drift_step     <= '0;
      drift_interval <= '0;
    end else begin
      if (wr_en && sel[RG_PERIOD])     period         <= wdata[PER_W-1:0];
      if (wr_en && sel[RG_ADJ_PER])    adj_period     <= wdata[PER_W-1:0];
      if (wr_en && sel[RG_DRIFT])      drift_step     <= wdata[DRIFT_W-1:0];
      if (wr_en && sel[RG_DRIFT_RATE]) drift_interval <= wdata[DRIFT_W-1:0];
      adj_start <= evt_cnt_write;
      if (evt_cnt_write) adj_count <= wdata[CNT_W-1:0];
    end
  end

  p_start_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_start |-> adj_count != '0);
  p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_start |-> $past(wr_en && sel[RG_ADJ_CNT]));
endmodule

// File: rtl/tod_host_regs.sv
module tod_host_regs
  import tod_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEC_W = 48,
  parameter int PER_W = 20,
  parameter int CNT_W = 20,
  parameter int DRIFT_W = 16,
  parameter logic [31:0] CLK_HZ = 32'd125_000_000,
  parameter logic [PER_W-1:0] NOMINAL_PERIOD = 20'h80000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               host_rvalid,
  input  logic [SEC_W-1:0]   live_sec,
  input  logic [31:0]        live_ns,
  input  logic [CNT_W-1:0]   live_adj_left,
  output logic               time_load,
  output logic [SEC_W-1:0]   load_sec,
  output logic [31:0]        load_ns,
  output logic [PER_W-1:0]   period,
  output logic [PER_W-1:0]   adj_period,
  output logic               adj_start,
  output logic [CNT_W-1:0]   adj_count,
  output logic [DRIFT_W-1:0] drift_step,
  output logic [DRIFT_W-1:0] drift_interval
);
  localparam int HI_W = SEC_W - 32;

  logic [NREG-1:0]  sel;
  logic             rd_en, wr_en;
  logic             evt_ns_read, evt_ns_write;
  logic [SEC_W-1:0] snap_sec;
  logic [31:0]      rd_mux;

  assign rd_en        = host_valid && !host_write;
  assign wr_en        = host_valid && host_write;
  assign evt_ns_read  = rd_en && sel[RG_NSEC];
  assign evt_ns_write = wr_en && sel[RG_NSEC];

  tod_addr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(host_addr), .sel(sel));

  tod_snapshot #(.SEC_W(SEC_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(evt_ns_read),
    .live_sec(live_sec), .snap_sec(snap_sec));

  tod_time_stage #(.SEC_W(SEC_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(wr_en && sel[RG_SEC_HI]), .wr_lo(wr_en && sel[RG_SEC_LO]),
    .wr_ns(evt_ns_write), .wdata(host_wdata),
    .time_load(time_load), .load_sec(load_sec), .load_ns(load_ns));

  tod_cfg_regs #(.PER_W(PER_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W),
                 .NOMINAL_PERIOD(NOMINAL_PERIOD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(host_wdata),
    .period(period), .adj_period(adj_period), .adj_start(adj_start),
    .adj_count(adj_count), .drift_step(drift_step), .drift_interval(drift_interval));

  always_comb begin
    rd_mux = '0;
    if (sel[RG_FREQ])       rd_mux = CLK_HZ;
    if (sel[RG_SEC_HI])     rd_mux = keep_low(32'(snap_sec[SEC_W-1:32]), HI_W);
    if (sel[RG_SEC_LO])     rd_mux = snap_sec[31:0];
    if (sel[RG_NSEC])       rd_mux = live_ns;
    if (sel[RG_PERIOD])     rd_mux = keep_low(32'(period), PER_W);
    if (sel[RG_ADJ_PER])    rd_mux = keep_low(32'(adj_period), PER_W);
    if (sel[RG_ADJ_CNT])    rd_mux = keep_low(32'(live_adj_left), CNT_W);
    if (sel[RG_DRIFT])      rd_mux = keep_low(32'(drift_step), DRIFT_W);
    if (sel[RG_DRIFT_RATE]) rd_mux = keep_low(32'(drift_interval), DRIFT_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_en;
      host_rdata  <= rd_en ? rd_mux : '0;
    end
  end

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> host_rvalid);
  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !host_rvalid);
  p_load_after_ns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ns_write |=> time_load);
  p_no_stray_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ns_write |=> !time_load);
  p_freq_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel[RG_FREQ] |=> host_rdata == CLK_HZ);
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (sel == '0) |=> host_rdata == '0);
endmodule

// File: tb/tod_host_regs_tb.sv
module tod_host_regs_tb;
  localparam logic [31:0] HZ  = 32'd125_000_000;
  localparam logic [19:0] NOM = 20'h80000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv = 1'b0, hw = 1'b0;
  logic [11:0] ha = '0;
  logic [31:0] hd = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [47:0] live_sec = '0;
  logic [31:0] live_ns = '0;
  logic [19:0] live_left = '0;
  logic        time_load, adj_start;
  logic [47:0] load_sec;
  logic [31:0] load_ns;
  logic [19:0] period, adj_period, adj_count;
  logic [15:0] drift_step, drift_interval;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_host_regs #(.CLK_HZ(HZ), .NOMINAL_PERIOD(NOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(hv), .host_write(hw), .host_addr(ha),
    .host_wdata(hd), .host_rdata(rdata), .host_rvalid(rvalid),
    .live_sec(live_sec), .live_ns(live_ns), .live_adj_left(live_left),
    .time_load(time_load), .load_sec(load_sec), .load_ns(load_ns),
    .period(period), .adj_period(adj_period), .adj_start(adj_start),
    .adj_count(adj_count), .drift_step(drift_step), .drift_interval(drift_interval));

  typedef struct packed { logic wr; logic [11:0] addr; logic [31:0] data; } vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h110, 32'hFFF12345}, '{1'b0, 12'h110, 32'h00012345},
    '{1'b1, 12'h114, 32'hFFFABCDE}, '{1'b0, 12'h114, 32'h000ABCDE},
    '{1'b1, 12'h11C, 32'hFFFF8001}, '{1'b0, 12'h11C, 32'h00008001},
    '{1'b1, 12'h120, 32'h12345678}, '{1'b0, 12'h120, 32'h00005678},
    '{1'b1, 12'h124, 32'hFFFFFFFF}, '{1'b0, 12'h124, 32'h00000000},
    '{1'b0, 12'h10C, 32'h00000000}, '{1'b0, 12'h000, 32'h00000000},
    '{1'b0, 12'h110, 32'h00012345}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); hv = 1'b1; hw = 1'b0; ha = a;
    @(negedge clk); hv = 1'b0; d = rdata; v = rvalid;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); hv = 1'b1; hw = 1'b1; ha = a; hd = d;
    @(negedge clk); hv = 1'b0; hw = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 period", 64'(period), 64'(NOM));
    chk("R1 adj_period", 64'(adj_period), 0);
    chk("R1 drift", 64'({drift_step, drift_interval}), 0);
    chk("R1 strobes", 64'({time_load, adj_start, rvalid}), 0);
    rd(12'h110, d, v);
    chk("R1 period readback", 64'(d), 64'(NOM));
    chk("R10 rvalid on read", 64'(v), 1);

    // R2 snapshot is zero before any nanosecond read
    live_sec = 48'hABCD_1234_5678; live_ns = 32'd999_999_999;
    rd(12'h104, d, v);
    chk("R2 snapshot before capture", 64'(d), 0);
    rd(12'h108, d, v);
    chk("R2 ns live", 64'(d), 64'd999_999_999);
    live_sec = 48'h0001_0000_0001; live_ns = 32'd5;
    rd(12'h104, d, v);
    chk("R2 R3 seconds low snapshot", 64'(d), 64'h1234_5678);
    rd(12'h100, d, v);
    chk("R2 R3 seconds high snapshot", 64'(d), 64'h0000_ABCD);
    rd(12'h108, d, v);
    rd(12'h100, d, v);
    chk("R2 recapture high", 64'(d), 64'h1);

    // R4 staged write and commit
    wr(12'h100, 32'hFFFF_0042);
    chk("R4 no load on high write", 64'(time_load), 0);
    chk("R10 no rvalid on write", 64'(rvalid), 0);
    wr(12'h104, 32'hDEAD_BEEF);
    chk("R4 no load on low write", 64'(time_load), 0);
    chk("R4 load_sec unchanged", 64'(load_sec), 0);
    wr(12'h108, 32'd123);
    chk("R4 load strobe", 64'(time_load), 1);
    chk("R4 load_sec", 64'(load_sec), 64'h0042_DEAD_BEEF);
    chk("R4 load_ns", 64'(load_ns), 64'd123);
    @(negedge clk);
    chk("R4 single-cycle strobe", 64'(time_load), 0);

    // R5 frequency word
    rd(12'h038, d, v);
    chk("R5 freq", 64'(d), 64'(HZ));
    wr(12'h038, 32'd5);
    rd(12'h038, d, v);
    chk("R5 freq after write", 64'(d), 64'(HZ));

    // R6/R9 vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d, v);
        chk($sformatf("R6/R9 vec %0d", i), 64'(d), 64'(VECS[i].data));
      end
    end
    chk("R6 period out", 64'(period), 64'h12345);
    chk("R6 adj_period out", 64'(adj_period), 64'hABCDE);
    chk("R6 drift outs", 64'({drift_step, drift_interval}), 64'h8001_5678);
    chk("R9 no load or start", 64'({time_load, adj_start}), 0);

    // R7 live remaining count
    live_left = 20'h00007;
    rd(12'h118, d, v);
    chk("R7 live count", 64'(d), 64'h7);
    live_left = 20'h0;
    rd(12'h118, d, v);
    chk("R7 finished count", 64'(d), 0);

    // R8 adjust start
    wr(12'h118, 32'hFFF0_0010);
    chk("R8 start strobe", 64'(adj_start), 1);
    chk("R8 count", 64'(adj_count), 64'h10);
    chk("R8 adj period held", 64'(adj_period), 64'hABCDE);
    @(negedge clk);
    chk("R8 single-cycle start", 64'(adj_start), 0);
    wr(12'h118, 32'hFFF0_0000);
    chk("R8 zero field no start", 64'(adj_start), 0);
    chk("R8 count kept", 64'(adj_count), 64'h10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule